// File: doc/BRIEF.md
# Handshake-Gated Round-Robin Arbiter

The block picks one winner among a set of level-sensitive requesters (eight by default) that share a single output port. It reports the winner as a binary index together with a valid flag. Both outputs are combinational functions of the present request vector and a stored rotating priority pointer. No output register stage sits between them and the pins.

A downstream ready input closes the handshake. The pointer moves past the winner only in a cycle where valid and ready are both high at the rising clock edge. A stalled cycle therefore leaves the fairness order untouched.

Each cycle falls into one of four named kinds. `CK_RESET` applies while reset is high and loads the pointer with zero. `CK_IDLE` applies when no request is present and holds the pointer. `CK_STALL` applies when a winner is offered but ready is low, and it also holds the pointer. `CK_ACCEPT` applies when a winner is offered and ready is high, and it loads the winner plus one, modulo the requester count. The pointer register is the only state the block keeps.

Top module: `rr_handshake_arbiter`

## Requirements
- R1: `win_valid` is high exactly when reset is low and at least one bit of `req_vec` is high; with no requests it is low.
- R2: `win_idx` (binary, bit i of `req_vec` is requester i) is the first high request met when searching upward from the current pointer, wrapping from the top requester back to requester 0.
- R3: A grant is accepted at a rising clock edge only when `win_valid` and `out_ready` are both high.
- R4: After requester k is accepted, the next search starts at requester (k+1) modulo the requester count.
- R5: In any cycle without acceptance (ready low or no requests), the pointer keeps its value.
- R6: Reset is synchronous and active-high; while it is high `win_valid` is low whatever `req_vec` holds, and the pointer returns to requester 0.
- R7: In the first cycle after reset is released, the search starts from requester 0 using the present `req_vec`.
- R8: `win_valid` and `win_idx` follow a change of `req_vec` within the same cycle, with no clock edge between.
- R9: A lone active requester is granted on every accepted cycle.
- R10: A requester held high through a stall keeps the grant until the grant is accepted.
- R11: For every pointer value and all request patterns, the winner equals the one found by a plain sequential search.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_vec | input | NUM_REQ | Level-sensitive request bits, one per requester |
| out_ready | input | 1 | Downstream accepts the offered winner this cycle |
| win_valid | output | 1 | A winner is offered |
| win_idx | output | IDX_W | Binary index of the offered winner |

## Verification
The bench builds the block with its default of eight requesters and a 3-bit index. With that size every pointer value can be reached, and the complete set of 256 request patterns can be swept at each one. Every pattern is compared against a sequential reference search. The eight-wide size also puts the wrap from requester 7 back to 0 within reach, along with the stall-hold and lone-requester cases, all driven from a short vector table.

// File: rtl/rr_arb_pkg.sv
package rr_arb_pkg;

    // Classification of one clock cycle, used to steer the pointer update.
    typedef enum logic [1:0] {
        CK_RESET  = 2'd0,
        CK_IDLE   = 2'd1,
        CK_STALL  = 2'd2,
        CK_ACCEPT = 2'd3
    } cycle_kind_t;

endpackage

// File: rtl/rr_rotate_search.sv
module rr_rotate_search #(
    parameter int NUM_REQ = 8,
    parameter int IDX_W   = $clog2(NUM_REQ)
) (
    input  logic [NUM_REQ-1:0] req_vec,
    input  logic [IDX_W-1:0]   start_ptr,
    output logic               any_req,
    output logic [IDX_W-1:0]   win_idx
);
    localparam int           DBL_W = 2 * NUM_REQ;
    localparam logic [IDX_W:0] N_EXT = (IDX_W + 1)'(NUM_REQ);

    logic [DBL_W-1:0]   dbl_req;
    logic [NUM_REQ-1:0] rot_req;
    logic [IDX_W-1:0]   offset;
    logic [IDX_W:0]     sum_ext;

    // Rotate so that the pointer position lands at bit 0.
    always_comb begin
        dbl_req = {req_vec, req_vec};
        for (int i = 0; i < NUM_REQ; i++) begin
            rot_req[i] = dbl_req[int'(start_ptr) + i];
        end
    end

    // Fixed-priority encoder: lowest set bit of the rotated vector wins.
    always_comb begin
        offset = '0;
        for (int i = NUM_REQ - 1; i >= 0; i--) begin
            if (rot_req[i]) offset = IDX_W'(i);
        end
    end

    // Add the pointer back, modulo the requester count.
    always_comb begin
        sum_ext = {1'b0, start_ptr} + {1'b0, offset};
        if (sum_ext >= N_EXT) win_idx = IDX_W'(sum_ext - N_EXT);
        else                  win_idx = sum_ext[IDX_W-1:0];
        any_req = |req_vec;
    end

endmodule

// File: rtl/rr_prio_ptr.sv
module rr_prio_ptr
    import rr_arb_pkg::*;
#(
    parameter int NUM_REQ = 8,
    parameter int IDX_W   = $clog2(NUM_REQ)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             any_req,
    input  logic             out_ready,
    input  logic [IDX_W-1:0] win_idx,
    output logic [IDX_W-1:0] prio_ptr
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REQ - 1);

    cycle_kind_t      kind;
    logic [IDX_W-1:0] ptr_nx;
    logic [IDX_W-1:0] after_win;

    always_comb begin
        if (rst)            kind = CK_RESET;
        else if (!any_req)  kind = CK_IDLE;
        else if (out_ready) kind = CK_ACCEPT;
        else                kind = CK_STALL;
    end

    always_comb begin
        after_win = (win_idx == LAST_IDX) ? '0 : win_idx + 1'b1;
        unique case (kind)
            CK_RESET:  ptr_nx = '0;
            CK_ACCEPT: ptr_nx = after_win;
            CK_IDLE:   ptr_nx = prio_ptr;
            CK_STALL:  ptr_nx = prio_ptr;
            default:   ptr_nx = prio_ptr;
        endcase
    end

    always_ff @(posedge clk) begin
        prio_ptr <= ptr_nx;
    end

endmodule

// File: rtl/rr_handshake_arbiter.sv
module rr_handshake_arbiter #(
    parameter int NUM_REQ = 8,
    parameter int IDX_W   = $clog2(NUM_REQ)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_REQ-1:0] req_vec,
    input  logic               out_ready,
    output logic               win_valid,
    output logic [IDX_W-1:0]   win_idx
);
    logic [IDX_W-1:0] prio_ptr;
    logic             any_req;
    logic [IDX_W-1:0] found_idx;

    rr_rotate_search #(
        .NUM_REQ (NUM_REQ),
        .IDX_W   (IDX_W)
    ) u_search (
        .req_vec   (req_vec),
        .start_ptr (prio_ptr),
        .any_req   (any_req),
        .win_idx   (found_idx)
    );

    rr_prio_ptr #(
        .NUM_REQ (NUM_REQ),
        .IDX_W   (IDX_W)
    ) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .any_req   (any_req),
        .out_ready (out_ready),
        .win_idx   (found_idx),
        .prio_ptr  (prio_ptr)
    );

    always_comb begin
        win_valid = any_req & ~rst;
        win_idx   = found_idx;
    end

endmodule

// File: rtl/rr_handshake_arbiter_chk.sv
module rr_handshake_arbiter_chk #(
    parameter int NUM_REQ = 8,
    parameter int IDX_W   = $clog2(NUM_REQ)
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_REQ-1:0] req_vec,
    input logic               out_ready,
    input logic               win_valid,
    input logic [IDX_W-1:0]   win_idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REQ - 1);

    logic               acc_q;
    logic               stall_q;
    logic               rst_q;
    logic [IDX_W-1:0]   nxt_q;
    logic [IDX_W-1:0]   idx_q;
    logic [NUM_REQ-1:0] req_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        nxt_q <= (win_idx == LAST_IDX) ? '0 : win_idx + 1'b1;
        idx_q <= win_idx;
        req_q <= req_vec;
        if (rst) begin
            acc_q   <= 1'b0;
            stall_q <= 1'b0;
        end else begin
            acc_q   <= win_valid && out_ready;
            stall_q <= win_valid && !out_ready;
        end
    end

    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        (req_vec == '0) |-> !win_valid);                          // R1

    AST_WIN_IS_REQUESTED: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> req_vec[win_idx]);                          // R2

    AST_ACCEPT_ROTATES: assert property (@(posedge clk) disable iff (rst)
        (acc_q && req_vec[nxt_q]) |-> (win_valid && win_idx == nxt_q)); // R4

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (stall_q && req_vec == req_q) |-> (win_valid && win_idx == idx_q)); // R10

    AST_RESET_NO_VALID: assert property (@(posedge clk)
        rst |-> !win_valid);                                      // R6

    AST_RESTART_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rst_q && req_vec[0]) |-> (win_idx == '0));               // R7

endmodule

bind rr_handshake_arbiter rr_handshake_arbiter_chk #(
    .NUM_REQ (NUM_REQ),
    .IDX_W   (IDX_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_vec   (req_vec),
    .out_ready (out_ready),
    .win_valid (win_valid),
    .win_idx   (win_idx)
);

// File: tb/rr_handshake_arbiter_test.sv
module rr_handshake_arbiter_test;
    localparam int  N      = 8;
    localparam int  IW     = 3;
    localparam time PERIOD = 20ns;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  req_vec = '0;
    logic          out_ready = 1'b0;
    logic          win_valid;
    logic [IW-1:0] win_idx;

    int total = 0;
    int bad   = 0;

    always #(PERIOD / 2) clk = ~clk;

    rr_handshake_arbiter #(.NUM_REQ(N), .IDX_W(IW)) uut (
        .clk       (clk),
        .rst       (rst),
        .req_vec   (req_vec),
        .out_ready (out_ready),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

    // Row: {req, ready, expected valid, expected index}; applied in order after reset.
    localparam int ROWS = 15;
    localparam logic [12:0] VEC [ROWS] = '{
        {8'hFF, 1'b1, 1'b1, 3'd0},  // R2 R4 ptr -> 1
        {8'hFF, 1'b1, 1'b1, 3'd1},  // R4 ptr -> 2
        {8'h81, 1'b1, 1'b1, 3'd7},  // R2 ptr -> 0 (wrap)
        {8'h81, 1'b1, 1'b1, 3'd0},  // R4 ptr -> 1
        {8'h81, 1'b0, 1'b1, 3'd7},  // R3 stall
        {8'h81, 1'b0, 1'b1, 3'd7},  // R10 still held
        {8'h81, 1'b1, 1'b1, 3'd7},  // R5 ptr was held, ptr -> 0
        {8'h00, 1'b1, 1'b0, 3'd0},  // R1 idle, ptr held
        {8'h10, 1'b1, 1'b1, 3'd4},  // R9 ptr -> 5
        {8'h10, 1'b1, 1'b1, 3'd4},  // R9
        {8'h10, 1'b1, 1'b1, 3'd4},  // R9
        {8'h06, 1'b1, 1'b1, 3'd1},  // R2 search 5..7,0,1; ptr -> 2
        {8'h06, 1'b1, 1'b1, 3'd2},  // R4 ptr -> 3
        {8'h40, 1'b0, 1'b1, 3'd6},  // R5 stall, ptr stays 3
        {8'h08, 1'b1, 1'b1, 3'd3}   // R5 ptr still 3
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int ref_pick(input logic [N-1:0] r, input int p);
        for (int k = 0; k < N; k++) begin
            if (r[(p + k) % N]) return (p + k) % N;
        end
        return -1;
    endfunction

    task automatic apply(input logic [N-1:0] r, input logic rdy);
        @(negedge clk);
        req_vec   = r;
        out_ready = rdy;
        #2;
    endtask

    initial begin
        #(PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R6: reset state, valid low with all requests high.
        apply(8'hFF, 1'b1);
        check(win_valid == 1'b0, "R6 valid low in reset", win_valid, 0);
        apply(8'hFF, 1'b1);
        check(win_valid == 1'b0, "R6 valid low in reset", win_valid, 0);

        // Table walk.
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < ROWS; i++) begin
            if (i != 0) @(negedge clk);
            req_vec   = VEC[i][12:5];
            out_ready = VEC[i][4];
            #2;
            check(win_valid == VEC[i][3], $sformatf("R1 row %0d valid", i),
                  win_valid, VEC[i][3]);
            if (VEC[i][3])
                check(win_idx == VEC[i][2:0], $sformatf("R2 row %0d idx", i),
                      win_idx, VEC[i][2:0]);
        end

        // R8: outputs follow requests within one cycle, no edge in between.
        @(negedge clk);
        out_ready = 1'b0;
        req_vec   = 8'h20;
        #1;
        check(win_valid && win_idx == 3'd5, "R8 first pattern", win_idx, 5);
        req_vec = 8'h02;
        #1;
        check(win_valid && win_idx == 3'd1, "R8 same cycle change", win_idx, 1);
        req_vec = 8'h00;
        #1;
        check(!win_valid, "R8 drop to idle", win_valid, 0);

        // R6 and R7: reset after pointer moved, then restart at requester 0.
        apply(8'h80, 1'b1);            // accept 7 -> ptr 0
        apply(8'h08, 1'b1);            // accept 3 -> ptr 4
        rst = 1'b1;
        apply(8'h81, 1'b0);
        check(!win_valid, "R6 valid low in mid-run reset", win_valid, 0);
        @(negedge clk);
        rst = 1'b0;
        #2;
        check(win_valid && win_idx == 3'd0, "R7 restart at zero", win_idx, 0);

        // R11: exhaustive sweep at each pointer value.
        for (int p = 0; p < N; p++) begin
            @(negedge clk);
            rst = 1'b1;
            out_ready = 1'b0;
            @(negedge clk);
            rst = 1'b0;
            if (p != 0) begin
                req_vec   = N'(1) << ((p + N - 1) % N);
                out_ready = 1'b1;
                @(negedge clk);
                out_ready = 1'b0;
            end
            for (int r = 0; r < (1 << N); r++) begin
                req_vec = N'(r);
                #1;
                if (r == 0)
                    check(!win_valid, $sformatf("R11 ptr %0d idle", p), win_valid, 0);
                else
                    check(win_valid && int'(win_idx) == ref_pick(N'(r), p),
                          $sformatf("R11 ptr %0d req %0d", p, r),
                          win_idx, ref_pick(N'(r), p));
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule